// File: doc/BRIEF.md
# Multi-Queue Deficit Weighted Scheduler

This block decides which of several transmit queues may send its next packet to a shared memory-read engine. Each queue raises a request and shows the byte length of the packet at its head. The scheduler answers with a registered one-hot grant and a grant-valid pulse. The queue that receives a grant treats it as permission to issue exactly one packet.

A two-bit mode input selects one of three policies. Fixed priority always favours the lowest index. Plain round robin rotates a pointer past each winner. Deficit weighted round robin gives each queue a byte budget. The budget is refilled by the queue weight times a shared increment factor, is capped at a programmable maximum, and is charged with the packet length, or with one unit when packet-count costing is selected. In the deficit mode, a queue marked strict skips the budget and is served ahead of all the others. Pause and reset are per-queue inputs. All configuration arrives on plain input ports.

Top module: `txq_dwrr_sched`

## Requirements
- R1: `gnt_o` is one-hot whenever `gnt_vld_o` is high and zero otherwise. It appears one clock after the request inputs it answers. A queue that was not requesting in that cycle is never granted.
- R2: Mode encoding: 0 is fixed priority, 1 is plain round robin, and 2 or 3 is deficit weighted. In fixed priority the eligible queue with the lowest index wins every cycle.
- R3: In round robin, the winner is the first eligible queue at or after a rotating pointer, searching upward and wrapping. The pointer then moves to the position after the winner.
- R4: In deficit mode, an eligible queue with its strict flag set wins ahead of all non-strict queues, with the lowest index first among strict queues. Deficits and the pointer stay unchanged in that cycle.
- R5: In deficit mode with no strict winner, the queue at the pointer is granted if it is eligible, non-strict, and holds a deficit at least equal to its cost. The cost is subtracted and the pointer stays.
- R6: Otherwise the pointer advances by one position, wrapping. If the queue it lands on is not paused, that queue's deficit gains weight times increment factor.
- R7: With `pkt_mode_i` high every grant costs 1. With it low, a grant costs the head packet byte length.
- R8: A paused queue is never granted, and its deficit is neither charged nor credited while it is paused.
- R9: Block reset loads every deficit with `def_init_i` and clears the pointer and outputs. A high `qrst_i[i]` loads queue i's deficit with `def_init_i` and blocks its grant in that cycle.
- R10: In deficit mode with equal packet lengths and all queues busy, each queue's long-run share of grants matches its share of total weight within 3 percent.
- R11: A credit never raises a deficit above `def_max_i`, so queues whose quantum exceeds the cap each receive the same number of grants per round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Arbitration policy select |
| pkt_mode_i | input | 1 | Charge one unit per grant instead of bytes |
| inc_factor_i | input | INC_W | Global multiplier for queue weights |
| def_max_i | input | DEF_W | Deficit ceiling |
| def_init_i | input | DEF_W | Deficit value loaded at reset |
| req_i | input | NQ | Per-queue request |
| len_i | input | NQ*LEN_W | Head packet byte length, queue i at bits [i*LEN_W +: LEN_W] |
| weight_i | input | NQ*WGT_W | Per-queue weight, same packing |
| strict_i | input | NQ | Per-queue bypass of the deficit policy |
| pause_i | input | NQ | Per-queue hold |
| qrst_i | input | NQ | Per-queue deficit reload |
| gnt_o | output | NQ | One-hot grant |
| gnt_vld_o | output | 1 | Grant valid pulse |

## Verification
On every cycle, the assertions check grant shape and that the grant follows a request, and that paused queues never win. They also check that strict queues pre-empt in deficit mode, that charges never drive a deficit negative, that credits respect the ceiling, and that a per-queue reset reloads the initial value. Only the bench scenarios can show the orderings: the rotation sequence, the long-run weight ratios in byte and packet costing, that deficits survive a pause, and that the cap flattens shares among heavily weighted queues. For these, a behavioural reference model is compared with the outputs every clock.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;

   typedef enum logic [1:0] {
      ARB_PRIO    = 2'd0,
      ARB_RR      = 2'd1,
      ARB_DWRR    = 2'd2,
      ARB_DWRR_B  = 2'd3
   } arb_mode_e;

endpackage

// File: rtl/txq_first_pick.sv
module txq_first_pick #(
   parameter int NQ     = 4,
   parameter bit ROTATE = 1'b0,
   localparam int IW    = (NQ > 1) ? $clog2(NQ) : 1
) (
   input  logic [NQ-1:0] cand_i,
   input  logic [IW-1:0] start_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);

   generate
      if (ROTATE) begin : g_rot
         always_comb begin
            found_o = 1'b0;
            idx_o   = '0;
            for (int k = NQ - 1; k >= 0; k--) begin
               int p;
               p = int'(start_i) + k;
               if (p >= NQ) p = p - NQ;
               if (cand_i[p]) begin
                  found_o = 1'b1;
                  idx_o   = IW'(p);
               end
            end
         end
      end else begin : g_fix
         logic [IW-1:0] unused_start;
         assign unused_start = start_i;
         always_comb begin
            found_o = 1'b0;
            idx_o   = '0;
            for (int k = NQ - 1; k >= 0; k--) begin
               if (cand_i[k]) begin
                  found_o = 1'b1;
                  idx_o   = IW'(k);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/txq_deficit.sv
module txq_deficit #(
   parameter int DEF_W = 20,
   parameter int QNT_W = 16,
   localparam int SUM_W = ((DEF_W > QNT_W) ? DEF_W : QNT_W) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             qrst_i,
   input  logic [DEF_W-1:0] init_i,
   input  logic [DEF_W-1:0] max_i,
   input  logic [QNT_W-1:0] quantum_i,
   input  logic             credit_i,
   input  logic             charge_i,
   input  logic [DEF_W-1:0] cost_i,
   output logic [DEF_W-1:0] def_o
);

   logic [DEF_W-1:0] def_q;
   logic [SUM_W-1:0] sum;
   logic [DEF_W-1:0] capped;

   always_comb begin
      sum    = SUM_W'(def_q) + SUM_W'(quantum_i);
      capped = (sum > SUM_W'(max_i)) ? max_i : sum[DEF_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        def_q <= init_i;
      else if (qrst_i)   def_q <= init_i;
      else if (charge_i) def_q <= def_q - cost_i;
      else if (credit_i) def_q <= capped;
   end

   assign def_o = def_q;

   AST_CHARGE_AFFORD: assert property (@(posedge clk) disable iff (!rst_n)
      charge_i |-> (def_q >= cost_i)); // R5
   AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (credit_i && !qrst_i && !charge_i) |=> (def_q <= $past(max_i))); // R11
   AST_QRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      qrst_i |=> (def_q == $past(init_i))); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!qrst_i && !charge_i && !credit_i) |=> (def_q == $past(def_q))); // R8

endmodule

// File: rtl/txq_dwrr_sched.sv
module txq_dwrr_sched
   import txq_sched_pkg::*;
#(
   parameter int NQ    = 4,
   parameter int LEN_W = 16,
   parameter int WGT_W = 8,
   parameter int INC_W = 8,
   parameter int DEF_W = 20,
   localparam int IW    = (NQ > 1) ? $clog2(NQ) : 1,
   localparam int QNT_W = WGT_W + INC_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode_i,
   input  logic                pkt_mode_i,
   input  logic [INC_W-1:0]    inc_factor_i,
   input  logic [DEF_W-1:0]    def_max_i,
   input  logic [DEF_W-1:0]    def_init_i,
   input  logic [NQ-1:0]       req_i,
   input  logic [NQ*LEN_W-1:0] len_i,
   input  logic [NQ*WGT_W-1:0] weight_i,
   input  logic [NQ-1:0]       strict_i,
   input  logic [NQ-1:0]       pause_i,
   input  logic [NQ-1:0]       qrst_i,
   output logic [NQ-1:0]       gnt_o,
   output logic                gnt_vld_o
);

   if (NQ < 2) begin : g_chk_nq
      $error("txq_dwrr_sched: NQ must be at least 2");
   end
   if (LEN_W > DEF_W) begin : g_chk_len
      $error("txq_dwrr_sched: LEN_W must not exceed DEF_W");
   end

   function automatic logic [IW-1:0] wrap_next(input logic [IW-1:0] p);
      return (int'(p) == NQ - 1) ? '0 : p + 1'b1;
   endfunction

   logic [IW-1:0]    ptr_q, ptr_d, ptr_nxt;
   logic [NQ-1:0]    elig;
   logic [NQ-1:0]    afford;
   logic [NQ-1:0]    charge;
   logic [NQ-1:0]    credit;
   logic [DEF_W-1:0] cost    [NQ];
   logic [DEF_W-1:0] deficit [NQ];
   logic [QNT_W-1:0] quantum [NQ];

   logic             prio_found, rr_found, strict_found;
   logic [IW-1:0]    prio_idx, rr_idx, strict_idx;
   logic             win_vld;
   logic [IW-1:0]    win_idx;
   logic             do_charge, do_adv;
   arb_mode_e        mode;

   assign mode    = arb_mode_e'(mode_i);
   assign elig    = req_i & ~pause_i & ~qrst_i;
   assign ptr_nxt = wrap_next(ptr_q);

   txq_first_pick #(.NQ(NQ), .ROTATE(1'b0)) u_prio (
      .cand_i(elig), .start_i(ptr_q), .found_o(prio_found), .idx_o(prio_idx));

   txq_first_pick #(.NQ(NQ), .ROTATE(1'b1)) u_rr (
      .cand_i(elig), .start_i(ptr_q), .found_o(rr_found), .idx_o(rr_idx));

   txq_first_pick #(.NQ(NQ), .ROTATE(1'b0)) u_strict (
      .cand_i(elig & strict_i), .start_i(ptr_q), .found_o(strict_found),
      .idx_o(strict_idx));

   always_comb begin
      win_vld   = 1'b0;
      win_idx   = '0;
      ptr_d     = ptr_q;
      do_charge = 1'b0;
      do_adv    = 1'b0;
      case (mode)
         ARB_PRIO: begin
            win_vld = prio_found;
            win_idx = prio_idx;
         end
         ARB_RR: begin
            win_vld = rr_found;
            win_idx = rr_idx;
            if (rr_found) ptr_d = wrap_next(rr_idx);
         end
         default: begin
            if (strict_found) begin
               win_vld = 1'b1;
               win_idx = strict_idx;
            end else if (elig[ptr_q] && !strict_i[ptr_q] && afford[ptr_q]) begin
               win_vld   = 1'b1;
               win_idx   = ptr_q;
               do_charge = 1'b1;
            end else begin
               do_adv = 1'b1;
               ptr_d  = ptr_nxt;
            end
         end
      endcase
   end

   for (genvar i = 0; i < NQ; i++) begin : g_q
      assign quantum[i] = QNT_W'(weight_i[i*WGT_W +: WGT_W]) * QNT_W'(inc_factor_i);
      assign cost[i]    = pkt_mode_i ? DEF_W'(1) : DEF_W'(len_i[i*LEN_W +: LEN_W]);
      assign afford[i]  = deficit[i] >= cost[i];
      assign charge[i]  = do_charge && (ptr_q == IW'(i));
      assign credit[i]  = do_adv && (ptr_nxt == IW'(i)) && !pause_i[i];

      txq_deficit #(.DEF_W(DEF_W), .QNT_W(QNT_W)) u_def (
         .clk      (clk),
         .rst_n    (rst_n),
         .qrst_i   (qrst_i[i]),
         .init_i   (def_init_i),
         .max_i    (def_max_i),
         .quantum_i(quantum[i]),
         .credit_i (credit[i]),
         .charge_i (charge[i]),
         .cost_i   (cost[i]),
         .def_o    (deficit[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_o     <= '0;
         gnt_vld_o <= 1'b0;
         ptr_q     <= '0;
      end else begin
         gnt_o     <= win_vld ? (NQ'(1) << win_idx) : '0;
         gnt_vld_o <= win_vld;
         ptr_q     <= ptr_d;
      end
   end

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld_o |-> $onehot(gnt_o)); // R1
   AST_GNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_vld_o |-> (gnt_o == '0)); // R1
   AST_GNT_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld_o |-> ((gnt_o & ~$past(req_i)) == '0)); // R1
   AST_PAUSE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld_o |-> ((gnt_o & ($past(pause_i) | $past(qrst_i))) == '0)); // R8
   AST_STRICT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(mode_i) >= 2'd2) &&
       (|($past(strict_i) & $past(req_i) & ~$past(pause_i) & ~$past(qrst_i))))
      |-> (|(gnt_o & $past(strict_i)))); // R4
   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr_q) < NQ); // R3

endmodule

// File: tb/txq_dwrr_sched_bench.sv
module txq_dwrr_sched_bench;

   localparam int NQ    = 4;
   localparam int LEN_W = 16;
   localparam int WGT_W = 8;
   localparam int INC_W = 8;
   localparam int DEF_W = 20;
   localparam time TCLK = 4ns;

   logic                clk = 1'b0;
   logic                rst_n;
   logic [1:0]          mode;
   logic                pkt_mode;
   logic [INC_W-1:0]    inc;
   logic [DEF_W-1:0]    dmax, dinit;
   logic [NQ-1:0]       req, strict, pause, qrst;
   logic [NQ*LEN_W-1:0] lens;
   logic [NQ*WGT_W-1:0] wts;
   logic [NQ-1:0]       gnt;
   logic                gnt_vld;

   always #(TCLK/2) clk = ~clk;

   txq_dwrr_sched #(.NQ(NQ), .LEN_W(LEN_W), .WGT_W(WGT_W), .INC_W(INC_W),
                    .DEF_W(DEF_W)) u_txq_dwrr_sched (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .pkt_mode_i(pkt_mode),
      .inc_factor_i(inc), .def_max_i(dmax), .def_init_i(dinit),
      .req_i(req), .len_i(lens), .weight_i(wts), .strict_i(strict),
      .pause_i(pause), .qrst_i(qrst), .gnt_o(gnt), .gnt_vld_o(gnt_vld));

   int    checks = 0, failures = 0;
   string tag = "R1";
   int    mdef [NQ];
   int    mptr;
   logic [NQ-1:0] ex_gnt;
   logic          ex_vld;
   int    cnt [NQ];

   task automatic chk(input bit ok, input string t, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
      end
   endtask

   function automatic int qlen(input int q);
      return int'(lens[q*LEN_W +: LEN_W]);
   endfunction
   function automatic int qwt(input int q);
      return int'(wts[q*WGT_W +: WGT_W]);
   endfunction

   task automatic model_step();
      int win = -1;
      bit el [NQ];
      if (!rst_n) begin
         for (int i = 0; i < NQ; i++) mdef[i] = int'(dinit);
         mptr = 0; ex_gnt = '0; ex_vld = 1'b0;
         return;
      end
      for (int i = 0; i < NQ; i++) el[i] = req[i] && !pause[i] && !qrst[i];
      if (mode == 2'd0) begin
         for (int i = 0; i < NQ; i++) if (el[i] && win < 0) win = i;
      end else if (mode == 2'd1) begin
         for (int k = 0; k < NQ; k++) if (el[(mptr + k) % NQ] && win < 0) win = (mptr + k) % NQ;
         if (win >= 0) mptr = (win + 1) % NQ;
      end else begin
         for (int i = 0; i < NQ; i++) if (el[i] && strict[i] && win < 0) win = i;
         if (win < 0) begin
            int c = pkt_mode ? 1 : qlen(mptr);
            if (el[mptr] && !strict[mptr] && mdef[mptr] >= c) begin
               win = mptr;
               mdef[mptr] -= c;
            end else begin
               mptr = (mptr + 1) % NQ;
               if (!pause[mptr]) begin
                  int s = mdef[mptr] + qwt(mptr) * int'(inc);
                  mdef[mptr] = (s > int'(dmax)) ? int'(dmax) : s;
               end
            end
         end
      end
      for (int i = 0; i < NQ; i++) if (qrst[i]) mdef[i] = int'(dinit);
      ex_gnt = (win >= 0) ? NQ'(1 << win) : '0;
      ex_vld = (win >= 0);
   endtask

   task automatic cyc(input int n);
      for (int j = 0; j < n; j++) begin
         model_step();
         @(posedge clk);
         #1;
         chk(gnt === ex_gnt && gnt_vld === ex_vld, tag, int'(gnt), int'(ex_gnt));
         for (int i = 0; i < NQ; i++) if (gnt_vld && gnt[i]) cnt[i]++;
      end
   endtask

   task automatic clr();
      for (int i = 0; i < NQ; i++) cnt[i] = 0;
   endtask

   task automatic ratio_chk(input string t);
      int tot = 0, ws = 0;
      for (int i = 0; i < NQ; i++) begin tot += cnt[i]; ws += qwt(i); end
      for (int i = 0; i < NQ; i++) begin
         int d = cnt[i] * ws - qwt(i) * tot;
         if (d < 0) d = -d;
         chk(tot > 0 && d * 100 <= 3 * tot * ws, t, cnt[i] * 1000 / (tot + 1), qwt(i) * 1000 / ws);
      end
   endtask

   initial begin
      #(TCLK * 200000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [NQ-1:0] seq [4];
      rst_n = 1'b0; mode = 2'd0; pkt_mode = 1'b0; inc = 8'd64;
      dmax = DEF_W'(4096); dinit = '0; req = '0; strict = '0; pause = '0; qrst = '0;
      lens = {16'd100, 16'd100, 16'd100, 16'd100};
      wts  = {8'd4, 8'd3, 8'd2, 8'd1};
      clr();
      tag = "R9"; cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk(gnt == '0 && !gnt_vld, "R9 reset outputs", int'(gnt), 0);

      // R2 fixed priority
      tag = "R2"; mode = 2'd0; req = 4'b1110; cyc(5);
      chk(gnt == 4'b0010, "R2 lowest index wins", int'(gnt), 2);
      req = 4'b1000; cyc(2);
      chk(gnt == 4'b1000, "R2 single requester", int'(gnt), 8);

      // R3 round robin rotation
      tag = "R3"; mode = 2'd1; req = 4'b1111;
      for (int j = 0; j < 4; j++) begin cyc(1); seq[j] = gnt; end
      chk(seq[0] == 4'b0001 && seq[1] == 4'b0010 && seq[2] == 4'b0100 && seq[3] == 4'b1000,
          "R3 rotation order", int'({seq[3], seq[2], seq[1], seq[0]}), 16'h8421);
      req = 4'b1010; cyc(6);
      chk(gnt_vld && (gnt == 4'b0010 || gnt == 4'b1000), "R3 skip idle", int'(gnt), 10);

      // R5 R6 R10 deficit byte mode
      tag = "R5"; mode = 2'd2; req = 4'b1111; clr(); cyc(3000);
      ratio_chk("R10 byte share");

      // R4 strict bypass
      tag = "R4"; strict = 4'b0100; clr(); cyc(20);
      chk(cnt[2] == 20, "R4 strict queue served every cycle", cnt[2], 20);
      strict = '0;

      // R8 pause keeps deficit
      tag = "R8"; pause = 4'b0010; clr(); cyc(300);
      chk(cnt[1] == 0, "R8 paused queue not granted", cnt[1], 0);
      chk(cnt[3] > 0, "R8 others continue", cnt[3], 1);
      pause = '0; tag = "R6"; cyc(300);

      // R9 per-queue reset
      tag = "R9"; dinit = DEF_W'(300); qrst = 4'b1000; cyc(1);
      qrst = '0; cyc(200);

      // R7 packet costing
      tag = "R7"; dinit = '0; qrst = 4'b1111; cyc(1); qrst = '0;
      pkt_mode = 1'b1; inc = 8'd1; lens = {16'd60000, 16'd60000, 16'd60000, 16'd60000};
      clr(); cyc(2000);
      ratio_chk("R7 packet share");

      // R11 ceiling
      tag = "R11"; pkt_mode = 1'b0; inc = 8'd64; dmax = DEF_W'(150);
      lens = {16'd100, 16'd100, 16'd100, 16'd100};
      qrst = 4'b1111; cyc(1); qrst = '0; clr(); cyc(2000);
      chk(cnt[2] - cnt[3] <= 1 && cnt[3] - cnt[2] <= 1, "R11 capped queues equal", cnt[3], cnt[2]);
      chk(cnt[0] < cnt[3], "R11 low weight below cap", cnt[0], cnt[3]);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule